// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves an 18-bit word between two bus ports, A and B, with a separate storage path for each direction. Each path has three operating modes. In pass-through mode the destination follows the source with no clock. In hold mode the destination keeps the last word it had. In clocked mode a new word is taken from the source on each falling edge of that path's strobe. A pass control picks pass-through. While pass is low, the strobe decides between holding and loading.

Each direction also has an output-drive control. The A-to-B drive is active high and the B-to-A drive is active low. The two ports are split into input, output and output-enable signals, so that a pad ring or a simulation can resolve the tri-state. A synchronous active-low reset clears a path's stored word on a falling strobe edge while that path's pass control is low. The two paths share no state. A system that enables both drives at once gets bus contention, and the system, not the block, must prevent it.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Each direction carries the full 18-bit word with every bit kept. This includes all-zero, all-one and alternating patterns.
- R2: While `ab_pass` is 1, `b_out` equals `a_in` in the same cycle. While `ba_pass` is 1, `a_out` equals `b_in`.
- R3: While a path's pass control is 0 and `rst_n` is 1, a falling edge of its strobe stores the source word. The destination output shows that word right after the edge.
- R4: While a path's pass control is 0, changes on the source and rising strobe edges leave the destination output unchanged. This holds whether the strobe rests high or low.
- R5: `b_oe` is 1 exactly when `ab_drive` is 1. `ab_drive` = 0 puts B in high impedance, whatever the other inputs are.
- R6: `a_oe` is 1 exactly when `ba_drive_n` is 0. The control is active low.
- R7: When a pass control falls, the destination keeps the last word seen during pass-through until the next falling strobe edge.
- R8: A falling strobe edge with `rst_n` = 0 and the pass control at 0 clears that path's stored word to zero.
- R9: Pass, strobe and data activity on one direction never changes the other direction's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low clear, taken on a falling strobe edge |
| a_in | input | 18 | Word read from port A |
| a_out | output | 18 | Word driven onto port A (B-to-A path) |
| a_oe | output | 1 | Port A output enable |
| b_in | input | 18 | Word read from port B |
| b_out | output | 18 | Word driven onto port B (A-to-B path) |
| b_oe | output | 1 | Port B output enable |
| ab_pass | input | 1 | A-to-B pass-through select, active high |
| ab_strobe | input | 1 | A-to-B load strobe, active on its falling edge |
| ab_drive | input | 1 | B port drive enable, active high |
| ba_pass | input | 1 | B-to-A pass-through select, active high |
| ba_strobe | input | 1 | B-to-A load strobe, active on its falling edge |
| ba_drive_n | input | 1 | A port drive enable, active low |

## Verification
Random words are sent through pass-through mode, where any added register stage would show up as a one-cycle lag. The same words are then sent with the pass control low, which separates a path that holds correctly from one that still leaks the source. Strobe-fall sequences are checked with data changed between edges, which shows whether the edge polarity and the latch-to-flop handover are right. Fixed extreme patterns, reset loads and drive-control sweeps cover bit integrity, clearing and enable polarity, and activity on one path while the other is held catches crosstalk between the directions.

// File: rtl/trx_pkg.sv
// Shared width and path-mode encoding for the bus transceiver.
package trx_pkg;
    localparam int unsigned TRX_WIDTH = 18;

    typedef enum logic [1:0] {
        PATH_PASS    = 2'd0,
        PATH_LATCHED = 2'd1,
        PATH_CLOCKED = 2'd2
    } path_mode_e;
endpackage

// File: rtl/trx_store.sv
// One direction's storage element: a transparent latch and a falling-edge
// register, merged by a flag that records which of them wrote last.
// Assumes the pass control and the source data do not change in the same instant.
module trx_store
    import trx_pkg::*;
#(
    parameter int unsigned W = TRX_WIDTH
) (
    input  logic         strobe,
    input  logic         pass,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q_out
);
    logic [W-1:0] lat_q;
    logic [W-1:0] reg_q;
    logic         reg_newer;
    path_mode_e   mode;

    // Latch follows the source while pass-through is selected.
    always_latch begin
        if (pass) lat_q <= din;
    end

    // Register loads (or clears under reset) on a falling strobe when not passing.
    always_ff @(negedge strobe) begin
        if (!pass) begin
            if (!rst_n) reg_q <= '0;
            else        reg_q <= din;
        end
    end

    // Marks the register as newest after a load; pass-through hands ownership back to the latch.
    always_ff @(negedge strobe or posedge pass) begin
        if (pass) reg_newer <= 1'b0;
        else      reg_newer <= 1'b1;
    end

    // Decode the present operating mode.
    always_comb begin
        if (pass)           mode = PATH_PASS;
        else if (reg_newer) mode = PATH_CLOCKED;
        else                mode = PATH_LATCHED;
    end

    // Select the word presented to the destination.
    always_comb begin
        case (mode)
            PATH_PASS:    q_out = din;
            PATH_LATCHED: q_out = lat_q;
            default:      q_out = reg_q;
        endcase
    end

    // A falling strobe with pass low must present the sampled source at the next falling strobe.
    assert_clocked_load_R3: assert property (@(negedge strobe) disable iff (!rst_n)
        !pass |=> (reg_q == $past(din)));
endmodule

// File: rtl/trx_drive.sv
// Output stage for one port: turns the drive control, of either polarity,
// into a split data/enable pair for the pad.
module trx_drive
    import trx_pkg::*;
#(
    parameter int unsigned W          = TRX_WIDTH,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic         drive_ctl,
    input  logic [W-1:0] data,
    output logic [W-1:0] pad_out,
    output logic         pad_oe
);
    logic en;

    generate
        if (ACTIVE_LOW) begin : g_low
            // Enable when the control is low.
            assign en = ~drive_ctl;
        end else begin : g_high
            // Enable when the control is high.
            assign en = drive_ctl;
        end
    endgenerate

    // Present the data and the resolved enable to the pad.
    assign pad_out = data;
    assign pad_oe  = en;
endmodule

// File: rtl/bus_xcvr_reg.sv
// Two-port registered transceiver. The A-to-B and B-to-A paths are independent,
// each with pass, strobe and drive controls. The ports are split for an external pad ring.
module bus_xcvr_reg
    import trx_pkg::*;
#(
    parameter int unsigned W = TRX_WIDTH
) (
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_pass,
    input  logic         ab_strobe,
    input  logic         ab_drive,
    input  logic         ba_pass,
    input  logic         ba_strobe,
    input  logic         ba_drive_n
);
    logic [W-1:0] ab_word;
    logic [W-1:0] ba_word;

    trx_store #(.W(W)) u_store_ab (
        .strobe(ab_strobe), .pass(ab_pass), .rst_n(rst_n), .din(a_in), .q_out(ab_word)
    );

    trx_store #(.W(W)) u_store_ba (
        .strobe(ba_strobe), .pass(ba_pass), .rst_n(rst_n), .din(b_in), .q_out(ba_word)
    );

    trx_drive #(.W(W), .ACTIVE_LOW(1'b0)) u_drive_b (
        .drive_ctl(ab_drive), .data(ab_word), .pad_out(b_out), .pad_oe(b_oe)
    );

    trx_drive #(.W(W), .ACTIVE_LOW(1'b1)) u_drive_a (
        .drive_ctl(ba_drive_n), .data(ba_word), .pad_out(a_out), .pad_oe(a_oe)
    );

    // Check that the drive enables follow their controls at the ports.
    always_comb begin
        if (ab_drive === 1'b0) assert_b_float_R5: assert (b_oe == 1'b0);
        if (ab_drive === 1'b1) assert_b_drive_R5: assert (b_oe == 1'b1);
        if (ba_drive_n === 1'b1) assert_a_float_R6: assert (a_oe == 1'b0);
        if (ba_drive_n === 1'b0) assert_a_drive_R6: assert (a_oe == 1'b1);
    end

    // Pass-through must show the source on the far port.
    assert_ab_pass_R2: assert property (@(negedge ab_strobe) disable iff (!rst_n)
        ab_pass |-> (b_out == a_in));
    assert_ba_pass_R2: assert property (@(negedge ba_strobe) disable iff (!rst_n)
        ba_pass |-> (a_out == b_in));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
    localparam int W = 18;

    logic tick = 1'b0;
    always #2 tick = ~tick;

    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_pass = 1'b0, ab_strobe = 1'b1, ab_drive = 1'b0;
    logic         ba_pass = 1'b0, ba_strobe = 1'b1, ba_drive_n = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    bus_xcvr_reg u0 (
        .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
        .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n)
    );

    // next-step drive values and reference model state
    logic [W-1:0] nx_a = '0, nx_b = '0;
    logic nx_abp = 0, nx_abs = 1, nx_abd = 0, nx_bap = 0, nx_bas = 1, nx_bad = 1, nx_rst = 0;
    logic [W-1:0] m_ab, m_ba;
    bit v_ab = 0, v_ba = 0, started = 0;
    string tag = "R8";
    int n_checks = 0, n_fail = 0, cycles = 0;

    task automatic check(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // apply the next-step values on a rising tick and advance the reference model
    task automatic step();
        @(posedge tick);
        if (nx_abp) begin m_ab = nx_a; v_ab = 1; end
        else if (ab_strobe && !nx_abs) begin m_ab = nx_rst ? nx_a : '0; v_ab = 1; end
        if (nx_bap) begin m_ba = nx_b; v_ba = 1; end
        else if (ba_strobe && !nx_bas) begin m_ba = nx_rst ? nx_b : '0; v_ba = 1; end
        a_in = nx_a; b_in = nx_b; rst_n = nx_rst;
        ab_pass = nx_abp; ab_drive = nx_abd; ba_pass = nx_bap; ba_drive_n = nx_bad;
        ab_strobe = nx_abs; ba_strobe = nx_bas;
    endtask

    task automatic pulse_ab();
        nx_abs = 0; step(); nx_abs = 1; step();
    endtask

    task automatic pulse_ba();
        nx_bas = 0; step(); nx_bas = 1; step();
    endtask

    // compare both ports with the model on every falling tick
    always @(negedge tick) begin
        cycles++;
        if (started) begin
            logic [W-1:0] eb, ea;
            eb = ab_pass ? a_in : m_ab;
            ea = ba_pass ? b_in : m_ba;
            if (v_ab || ab_pass) check(b_out === eb, "b_out", b_out, eb);
            if (v_ba || ba_pass) check(a_out === ea, "a_out", a_out, ea);
            check(b_oe === ab_drive, "b_oe", {17'b0, b_oe}, {17'b0, ab_drive});
            check(a_oe === !ba_drive_n, "a_oe", {17'b0, a_oe}, {17'b0, !ba_drive_n});
        end
    end

    // watchdog
    initial begin
        wait (cycles > 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R8: reset clears both stored words on a falling strobe
        tag = "R8";
        nx_a = 18'h2AAAA; nx_b = 18'h15555;
        step(); pulse_ab(); pulse_ba();
        started = 1;
        nx_rst = 1; step(); step();
        check(b_out === '0, "reset b", b_out, '0);
        check(a_out === '0, "reset a", a_out, '0);

        // R5 and R6: drive enable polarities
        tag = "R5"; nx_abd = 1; step(); nx_abd = 0; step();
        tag = "R6"; nx_bad = 0; step(); nx_bad = 1; step();

        // R2: pass-through with random words in both directions
        tag = "R2"; nx_abp = 1; nx_bap = 1;
        for (int i = 0; i < 10; i++) begin
            nx_a = W'($urandom); nx_b = W'($urandom); step();
        end

        // R7: drop pass, then change sources; the last passed word must stay
        tag = "R7"; nx_abp = 0; nx_bap = 0; step();
        for (int i = 0; i < 5; i++) begin
            nx_a = W'($urandom); nx_b = W'($urandom); step();
        end

        // R3: clocked loads with data changed between edges
        tag = "R3";
        for (int i = 0; i < 8; i++) begin
            nx_a = W'($urandom); nx_b = W'($urandom); step();
            pulse_ab(); pulse_ba();
        end

        // R4: strobe held low, then high, with source changes and a rising edge
        tag = "R4"; nx_abs = 0; nx_bas = 0; step();
        for (int i = 0; i < 4; i++) begin
            nx_a = W'($urandom); nx_b = W'($urandom); step();
        end
        nx_abs = 1; nx_bas = 1; step();
        for (int i = 0; i < 4; i++) begin
            nx_a = W'($urandom); nx_b = W'($urandom); step();
        end

        // R9: B-to-A activity while A-to-B holds, and the reverse
        tag = "R9"; nx_a = W'($urandom); step(); pulse_ab();
        for (int i = 0; i < 4; i++) begin
            nx_b = W'($urandom); nx_bap = i[0]; step(); pulse_ba();
        end
        nx_bap = 0; step();
        for (int i = 0; i < 4; i++) begin
            nx_a = W'($urandom); nx_abp = i[0]; step(); pulse_ab();
        end
        nx_abp = 0; step();

        // R1: extreme bit patterns loaded through both paths
        tag = "R1";
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] p;
            p = (i == 0) ? '0 : (i == 1) ? '1 : (i == 2) ? 18'h2AAAA : 18'h15555;
            nx_a = p; nx_b = ~p; step(); pulse_ab(); pulse_ba();
            check(b_out === p, "pattern b", b_out, p);
            check(a_out === ~p, "pattern a", a_out, ~p);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule